// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block turns a 16-bit local CPU address into a 20-bit global byte address through two 8-bit page index registers. One index pages 4 KB blocks of RAM into a local window at 0x1000–0x1FFF. The other pages 1 KB blocks of EEPROM into a local window at 0x0800–0x0BFF. Two further local ranges, 0x2000–0x2FFF and 0x3000–0x3FFF, are tied to the last two RAM pages and do not depend on the index. For every local address the block returns a global address, a target code and a hit flag. Any other address passes through unchanged.

The two index registers sit on a small register bus, and their values can be read back at any time. The bus has a CPU write port and a write port for a second master. When both masters write the same register in one cycle, the CPU write wins. The reset values of the indices are chosen so that 0x1000–0x3FFF forms one linear 12 KB RAM range right after reset.

Top module: `paged_xlate`

## Requirements
- R1: A synchronous active-low reset sets the RAM index to 0xFD and the EEPROM index to 0xFE.
- R2: A local address in 0x1000–0x1FFF gives target 1 (RAM), hit 1, and the global address {RAM index, local[11:0]}.
- R3: A local address in 0x2000–0x2FFF gives target 1, hit 1, and the global address {0xFE, local[11:0]}, whatever the RAM index holds.
- R4: A local address in 0x3000–0x3FFF gives target 1, hit 1, and the global address {0xFF, local[11:0]}, whatever the RAM index holds.
- R5: With the reset index values, the global address for every local address in 0x1000–0x3FFF equals 0xFD000 + (local − 0x1000).
- R6: A local address in 0x0800–0x0BFF gives target 2 (EEPROM), hit 1, and the global address {2'b00, EEPROM index, local[9:0]}.
- R7: Any other local address gives target 0, hit 0, and the global address {4'h0, local}. At most one region matches at a time.
- R8: A write with register address 0x16 loads the RAM index, and a write with register address 0x17 loads the EEPROM index. The new value is used for translations from the next clock cycle on, not in the cycle of the write.
- R9: If both masters write the same index register in one cycle, the CPU data is stored. If they write different registers, both writes take effect.
- R10: A write from either master to any other register address changes neither index.
- R11: The read port returns the RAM index at address 0x16, the EEPROM index at 0x17 and zero at any other address, combinationally and at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 8 | CPU register write address |
| cpu_wdata | input | 8 | CPU register write data |
| m2_wr | input | 1 | Second master write strobe |
| m2_addr | input | 8 | Second master write address |
| m2_wdata | input | 8 | Second master write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data |
| loc_addr | input | 16 | Local CPU address to translate |
| glob_addr | output | 20 | Translated global byte address |
| target | output | 2 | 0 pass-through, 1 RAM, 2 EEPROM |
| hit | output | 1 | Local address lies in a paged or fixed region |

## Verification
A wrong index register shows up at the read port and in every translation through its window, and it does so in the same cycle. A write that arrives one cycle early or late shows as a glob_addr value in the cycle around the write edge. A decoder that matches the wrong region, or two regions at once, shows up in target and in the upper global bits for the range it affects. The bench probes the range edges to catch these. Checks made against a bench-side reference model after random writes from both masters cover the arbitration and the write-ignore cases.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int LADDR_W   = 16;
  localparam int PAGE_W    = 8;
  localparam int RAM_OFS_W = 12;
  localparam int EE_OFS_W  = 10;
  localparam int GADDR_W   = PAGE_W + RAM_OFS_W;
  localparam int REG_AW    = 8;

  typedef enum logic [1:0] {
    TGT_PASS = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_EE   = 2'd2
  } tgt_e;

  // RAM global address: page on top of the 4 KB offset
  function automatic logic [GADDR_W-1:0] ram_global(
    input logic [PAGE_W-1:0] pg, input logic [LADDR_W-1:0] la);
    return {pg, la[RAM_OFS_W-1:0]};
  endfunction

  // EEPROM global address: page on top of the 1 KB offset, zero-extended
  function automatic logic [GADDR_W-1:0] ee_global(
    input logic [PAGE_W-1:0] pg, input logic [LADDR_W-1:0] la);
    return GADDR_W'({pg, la[EE_OFS_W-1:0]});
  endfunction

  function automatic logic [GADDR_W-1:0] pass_global(input logic [LADDR_W-1:0] la);
    return GADDR_W'(la);
  endfunction
endpackage

// File: rtl/pxl_page_regs.sv
module pxl_page_regs
  import pxl_pkg::*;
#(
  parameter int NREG = 2,
  parameter logic [NREG*REG_AW-1:0] ADDRS = {8'h17, 8'h16},
  parameter logic [NREG*PAGE_W-1:0] RSTS  = {8'hFE, 8'hFD}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_wr,
  input  logic [REG_AW-1:0]      cpu_addr,
  input  logic [PAGE_W-1:0]      cpu_wdata,
  input  logic                   m2_wr,
  input  logic [REG_AW-1:0]      m2_addr,
  input  logic [PAGE_W-1:0]      m2_wdata,
  input  logic [REG_AW-1:0]      rd_addr,
  output logic [PAGE_W-1:0]      rd_data,
  output logic [NREG*PAGE_W-1:0] pages,
  output logic [NREG-1:0]        cpu_sel,
  output logic [NREG-1:0]        m2_sel
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [REG_AW-1:0] A = ADDRS[i*REG_AW +: REG_AW];
    localparam logic [PAGE_W-1:0] R = RSTS[i*PAGE_W +: PAGE_W];
    logic [PAGE_W-1:0] q;

    assign cpu_sel[i] = cpu_wr && (cpu_addr == A);
    assign m2_sel[i]  = m2_wr && (m2_addr == A);

    // CPU has priority over the second master
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= R;
      else if (cpu_sel[i]) q <= cpu_wdata;
      else if (m2_sel[i])  q <= m2_wdata;
    end

    assign pages[i*PAGE_W +: PAGE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDRS[i*REG_AW +: REG_AW]) rd_data = pages[i*PAGE_W +: PAGE_W];
  end
endmodule

// File: rtl/pxl_window_decode.sv
module pxl_window_decode
  import pxl_pkg::*;
#(
  parameter logic [3:0] WIN_TAG   = 4'h1,
  parameter logic [3:0] FIXLO_TAG = 4'h2,
  parameter logic [3:0] FIXHI_TAG = 4'h3,
  parameter logic [5:0] EE_TAG    = 6'b000010
) (
  input  logic [LADDR_W-1:0] loc_addr,
  output logic               in_win,
  output logic               in_flo,
  output logic               in_fhi,
  output logic               in_ee
);
  localparam int RAM_TAG_W = LADDR_W - RAM_OFS_W;
  localparam int EE_TAG_W  = LADDR_W - EE_OFS_W;

  logic [RAM_TAG_W-1:0] ram_tag;
  logic [EE_TAG_W-1:0]  ee_tag;

  assign ram_tag = loc_addr[LADDR_W-1:RAM_OFS_W];
  assign ee_tag  = loc_addr[LADDR_W-1:EE_OFS_W];

  assign in_win = (ram_tag == RAM_TAG_W'(WIN_TAG));
  assign in_flo = (ram_tag == RAM_TAG_W'(FIXLO_TAG));
  assign in_fhi = (ram_tag == RAM_TAG_W'(FIXHI_TAG));
  assign in_ee  = (ee_tag  == EE_TAG_W'(EE_TAG));
endmodule

// File: rtl/pxl_addr_compose.sv
module pxl_addr_compose
  import pxl_pkg::*;
#(
  parameter logic [PAGE_W-1:0] FIXLO_PAGE = 8'hFE,
  parameter logic [PAGE_W-1:0] FIXHI_PAGE = 8'hFF
) (
  input  logic [LADDR_W-1:0] loc_addr,
  input  logic               in_win,
  input  logic               in_flo,
  input  logic               in_fhi,
  input  logic               in_ee,
  input  logic [PAGE_W-1:0]  ram_page,
  input  logic [PAGE_W-1:0]  ee_page,
  output logic [GADDR_W-1:0] glob_addr,
  output tgt_e               target,
  output logic               hit
);
  always_comb begin
    glob_addr = pass_global(loc_addr);
    target    = TGT_PASS;
    if (in_win) begin
      glob_addr = ram_global(ram_page, loc_addr);
      target    = TGT_RAM;
    end else if (in_flo) begin
      glob_addr = ram_global(FIXLO_PAGE, loc_addr);
      target    = TGT_RAM;
    end else if (in_fhi) begin
      glob_addr = ram_global(FIXHI_PAGE, loc_addr);
      target    = TGT_RAM;
    end else if (in_ee) begin
      glob_addr = ee_global(ee_page, loc_addr);
      target    = TGT_EE;
    end
  end

  assign hit = (target != TGT_PASS);
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
  import pxl_pkg::*;
#(
  parameter logic [REG_AW-1:0] RAM_REG  = 8'h16,
  parameter logic [REG_AW-1:0] EE_REG   = 8'h17,
  parameter logic [PAGE_W-1:0] RAM_RST  = 8'hFD,
  parameter logic [PAGE_W-1:0] EE_RST   = 8'hFE,
  parameter logic [PAGE_W-1:0] FIXLO_PG = 8'hFE,
  parameter logic [PAGE_W-1:0] FIXHI_PG = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_wr,
  input  logic [REG_AW-1:0]   cpu_addr,
  input  logic [PAGE_W-1:0]   cpu_wdata,
  input  logic                m2_wr,
  input  logic [REG_AW-1:0]   m2_addr,
  input  logic [PAGE_W-1:0]   m2_wdata,
  input  logic [REG_AW-1:0]   rd_addr,
  output logic [PAGE_W-1:0]   rd_data,
  input  logic [LADDR_W-1:0]  loc_addr,
  output logic [GADDR_W-1:0]  glob_addr,
  output logic [1:0]          target,
  output logic                hit
);
  localparam int NREG = 2;

  logic [NREG*PAGE_W-1:0] pages;
  logic [NREG-1:0]        cpu_sel, m2_sel;
  logic [PAGE_W-1:0]      ram_page, ee_page;
  logic                   in_win, in_flo, in_fhi, in_ee;
  tgt_e                   tgt;

  pxl_page_regs #(
    .NREG (NREG),
    .ADDRS({EE_REG, RAM_REG}),
    .RSTS ({EE_RST, RAM_RST})
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .m2_wr    (m2_wr),
    .m2_addr  (m2_addr),
    .m2_wdata (m2_wdata),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pages    (pages),
    .cpu_sel  (cpu_sel),
    .m2_sel   (m2_sel)
  );

  assign ram_page = pages[0 +: PAGE_W];
  assign ee_page  = pages[PAGE_W +: PAGE_W];

  pxl_window_decode u_dec (
    .loc_addr(loc_addr),
    .in_win  (in_win),
    .in_flo  (in_flo),
    .in_fhi  (in_fhi),
    .in_ee   (in_ee)
  );

  pxl_addr_compose #(
    .FIXLO_PAGE(FIXLO_PG),
    .FIXHI_PAGE(FIXHI_PG)
  ) u_cmp (
    .loc_addr (loc_addr),
    .in_win   (in_win),
    .in_flo   (in_flo),
    .in_fhi   (in_fhi),
    .in_ee    (in_ee),
    .ram_page (ram_page),
    .ee_page  (ee_page),
    .glob_addr(glob_addr),
    .target   (tgt),
    .hit      (hit)
  );

  assign target = tgt;
endmodule

// File: rtl/pxl_checker.sv
module pxl_checker
  import pxl_pkg::*;
#(
  parameter logic [REG_AW-1:0] RAM_REG = 8'h16,
  parameter logic [REG_AW-1:0] EE_REG  = 8'h17
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_wr,
  input logic [REG_AW-1:0]   cpu_addr,
  input logic [PAGE_W-1:0]   cpu_wdata,
  input logic                m2_wr,
  input logic [REG_AW-1:0]   m2_addr,
  input logic [PAGE_W-1:0]   m2_wdata,
  input logic [LADDR_W-1:0]  loc_addr,
  input logic [GADDR_W-1:0]  glob_addr,
  input logic [1:0]          target,
  input logic                hit,
  input logic [PAGE_W-1:0]   ram_page,
  input logic [PAGE_W-1:0]   ee_page,
  input logic                in_win,
  input logic                in_flo,
  input logic                in_fhi,
  input logic                in_ee
);
  logic cpu_ram, m2_ram, cpu_ee, m2_ee;
  assign cpu_ram = cpu_wr && (cpu_addr == RAM_REG);
  assign m2_ram  = m2_wr && (m2_addr == RAM_REG);
  assign cpu_ee  = cpu_wr && (cpu_addr == EE_REG);
  assign m2_ee   = m2_wr && (m2_addr == EE_REG);

  a_r7_single_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_win, in_flo, in_fhi, in_ee}));

  a_r2_window_page: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (glob_addr[GADDR_W-1:RAM_OFS_W] == ram_page) && (target == 2'd1) && hit);

  a_r3_fixed_lo: assert property (@(posedge clk) disable iff (!rst_n)
    in_flo |-> (glob_addr[GADDR_W-1:RAM_OFS_W] == 8'hFE) && (target == 2'd1));

  a_r4_fixed_hi: assert property (@(posedge clk) disable iff (!rst_n)
    in_fhi |-> (glob_addr[GADDR_W-1:RAM_OFS_W] == 8'hFF) && (target == 2'd1));

  a_r6_ee_page: assert property (@(posedge clk) disable iff (!rst_n)
    in_ee |-> (glob_addr[GADDR_W-1:EE_OFS_W] == {2'b00, ee_page}) && (target == 2'd2));

  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (glob_addr == GADDR_W'(loc_addr)) && (target == 2'd0));

  a_r8_cpu_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ram |=> (ram_page == $past(cpu_wdata)));

  a_r9_cpu_wins_ee: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ee && m2_ee) |=> (ee_page == $past(cpu_wdata)));

  a_r9_m2_ee_write: assert property (@(posedge clk) disable iff (!rst_n)
    (m2_ee && !cpu_ee) |=> (ee_page == $past(m2_wdata)));

  a_r10_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ram && !m2_ram) |=> $stable(ram_page));

  a_r10_ee_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ee && !m2_ee) |=> $stable(ee_page));
endmodule

bind paged_xlate pxl_checker #(.RAM_REG(RAM_REG), .EE_REG(EE_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_wr   (cpu_wr),
  .cpu_addr (cpu_addr),
  .cpu_wdata(cpu_wdata),
  .m2_wr    (m2_wr),
  .m2_addr  (m2_addr),
  .m2_wdata (m2_wdata),
  .loc_addr (loc_addr),
  .glob_addr(glob_addr),
  .target   (target),
  .hit      (hit),
  .ram_page (ram_page),
  .ee_page  (ee_page),
  .in_win   (in_win),
  .in_flo   (in_flo),
  .in_fhi   (in_fhi),
  .in_ee    (in_ee)
);

// File: tb/tb_paged_xlate.sv
module tb_paged_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0, m2_wr = 1'b0;
  logic [7:0]  cpu_addr = '0, cpu_wdata = '0, m2_addr = '0, m2_wdata = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] loc_addr = '0;
  logic [19:0] glob_addr;
  logic [1:0]  target;
  logic        hit;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_ram, m_ee;   // bench model of the index registers

  always #2.5 clk = ~clk;   // 200 MHz

  paged_xlate dut (.*);

  // {local, expected global, expected target}; hit is 1 when target != 0
  localparam int NV = 13;
  localparam logic [37:0] VEC [NV] = '{
    {16'h1000, 20'hFD000, 2'd1},
    {16'h1FFF, 20'hFDFFF, 2'd1},
    {16'h2000, 20'hFE000, 2'd1},
    {16'h2ABC, 20'hFEABC, 2'd1},
    {16'h3000, 20'hFF000, 2'd1},
    {16'h3FFF, 20'hFFFFF, 2'd1},
    {16'h0800, 20'h3F800, 2'd2},
    {16'h0BFF, 20'h3FBFF, 2'd2},
    {16'h07FF, 20'h007FF, 2'd0},
    {16'h0C00, 20'h00C00, 2'd0},
    {16'h4000, 20'h04000, 2'd0},
    {16'hFFFF, 20'h0FFFF, 2'd0},
    {16'h0000, 20'h00000, 2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent reference written as arithmetic on page sizes
  task automatic ref_xlate(input logic [15:0] a, input logic [7:0] rp, input logic [7:0] ep,
                           output logic [19:0] g, output logic [1:0] t);
    int ai;
    ai = int'(a);
    if (ai >= 'h1000 && ai < 'h2000)      begin g = 20'(int'(rp) * 4096 + ai - 'h1000); t = 2'd1; end
    else if (ai >= 'h2000 && ai < 'h4000) begin g = 20'('hFE000 + ai - 'h2000);        t = 2'd1; end
    else if (ai >= 'h0800 && ai < 'h0C00) begin g = 20'(int'(ep) * 1024 + ai - 'h0800); t = 2'd2; end
    else                                  begin g = 20'(ai);                            t = 2'd0; end
  endtask

  task automatic xcheck(input string req, input logic [15:0] a);
    logic [19:0] g; logic [1:0] t;
    @(negedge clk);
    loc_addr = a;
    #1;
    ref_xlate(a, m_ram, m_ee, g, t);
    check(req, {10'b0, hit, target, glob_addr}, {10'b0, (t != 2'd0), t, g});
  endtask

  task automatic wr(input bit ce, input logic [7:0] ca, input logic [7:0] cd,
                    input bit me, input logic [7:0] ma, input logic [7:0] md);
    @(negedge clk);
    cpu_wr = ce; cpu_addr = ca; cpu_wdata = cd;
    m2_wr = me; m2_addr = ma; m2_wdata = md;
    @(negedge clk);
    cpu_wr = 1'b0; m2_wr = 1'b0;
    // model: CPU first, second master only if it did not collide
    if (ce && ca == 8'h16) m_ram = cd; else if (me && ma == 8'h16) m_ram = md;
    if (ce && ca == 8'h17) m_ee = cd;  else if (me && ma == 8'h17) m_ee = md;
  endtask

  task automatic rdchk(input string req);
    @(negedge clk);
    rd_addr = 8'h16; #1; check(req, {24'b0, rd_data}, {24'b0, m_ram});
    rd_addr = 8'h17; #1; check(req, {24'b0, rd_data}, {24'b0, m_ee});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ram = 8'hFD; m_ee = 8'hFE;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R11: reset values and read of an unused address
    rdchk("R1");
    @(negedge clk); rd_addr = 8'h20; #1; check("R11 unused read", {24'b0, rd_data}, 32'h0);

    // R2 R3 R4 R6 R7: vector table at reset pages
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      loc_addr = VEC[i][37:22];
      #1;
      check("R2/R3/R4/R6/R7 table", {10'b0, hit, target, glob_addr},
            {10'b0, (VEC[i][1:0] != 2'd0), VEC[i][1:0], VEC[i][21:2]});
    end

    // R5: linear 12 KB after reset
    for (int a = 'h1000; a < 'h4000; a += 'h0FF) begin
      @(negedge clk); loc_addr = 16'(a); #1;
      check("R5 linear", {12'b0, glob_addr}, 32'('hFD000 + a - 'h1000));
    end

    // R8: write takes effect next cycle
    @(negedge clk);
    loc_addr = 16'h1234; cpu_wr = 1'b1; cpu_addr = 8'h16; cpu_wdata = 8'h42;
    #1; check("R8 old page in write cycle", {12'b0, glob_addr}, 32'hFD234);
    @(negedge clk); cpu_wr = 1'b0; m_ram = 8'h42;
    #1; check("R8 new page after edge", {12'b0, glob_addr}, 32'h42234);
    rdchk("R8 readback");
    xcheck("R3 alias ignores index", 16'h2345);
    xcheck("R4 alias ignores index", 16'h3ABC);

    // R9: same-register collision, then split writes
    wr(1, 8'h16, 8'h11, 1, 8'h16, 8'h99);
    rdchk("R9 cpu wins ram");
    wr(1, 8'h17, 8'h5A, 1, 8'h17, 8'hA5);
    rdchk("R9 cpu wins ee");
    wr(1, 8'h16, 8'h22, 1, 8'h17, 8'h33);
    rdchk("R9 split writes");
    wr(0, 8'h00, 8'h00, 1, 8'h17, 8'h05);
    xcheck("R6 ee after m2 write", 16'h0800);
    @(negedge clk); #1; check("R6 ee page 5", {12'b0, glob_addr}, 32'h01400);

    // R10: writes elsewhere are ignored
    wr(1, 8'h18, 8'hCC, 1, 8'h15, 8'hDD);
    rdchk("R10 ignored");
    xcheck("R10 translation unchanged", 16'h1ABC);

    // Random writes from both masters against the reference
    for (int i = 0; i < 60; i++) begin
      logic [7:0] ra, rb;
      ra = ($urandom % 4 == 0) ? 8'($urandom) : 8'h16 + 8'($urandom % 2);
      rb = ($urandom % 4 == 0) ? 8'($urandom) : 8'h16 + 8'($urandom % 2);
      wr(1'($urandom), ra, 8'($urandom), 1'($urandom), rb, 8'($urandom));
      xcheck("R2/R6/R9 random", 16'($urandom % 'h5000));
      xcheck("R7 random", 16'($urandom));
    end
    rdchk("R11 random readback");

    // R1: reset mid-run restores the indices
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_ram = 8'hFD; m_ee = 8'hFE;
    rdchk("R1 re-reset");
    xcheck("R5 after re-reset", 16'h1800);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule